// File: doc/BRIEF.md
# Video RAM Arbiter

This block lets two users share one single-ported static RAM that is built from byte-wide chips placed side by side to form one word. The display fetch side reads pixel words in scan order and cannot be made to wait for long. The other side carries CPU frame-buffer writes that were captured from a host bus, and these can wait. The arbiter runs everything from one clock. It produces the chip-enable, output-enable, per-byte write-enable and address signals, and it also controls the direction of the data bus.

Reads always win. When a write is requested while reads are still pending, the write is held back until the read side goes quiet. A write never overlaps a read, and the data pins have a full clock to turn around after a write before the next read enables the RAM outputs. Each user holds its request high until the arbiter answers it. A read is answered with a grant pulse and later with a data-valid pulse. A write is answered with a done pulse.

Top module: `vram_arbiter`

## Requirements
- R1: `mem_oe_n` is never low in the same cycle as `mem_dq_oe` high or any bit of `mem_we_n` low.
- R2: A read takes two clocks. `rd_gnt` is high during the first, with `mem_ce_n` and `mem_oe_n` low and `mem_addr` equal to the requested address. `rd_valid` is high, with `rd_data` holding the word read, exactly two clocks after the `rd_gnt` cycle.
- R3: A write takes three clocks. Setup has `mem_ce_n` low, `mem_dq_oe` high and all `mem_we_n` high. Strobe has write-enables low and `wr_done` high. Release has `mem_dq_oe` still high, `mem_ce_n` high and all `mem_we_n` high.
- R4: When both requests are raised together while the arbiter is idle, the read is granted first and the write follows it.
- R5: While `rd_req` stays high, reads are granted on every other clock, and no write strobe or `wr_done` occurs until `rd_req` falls.
- R6: A read raised in the setup clock of a write is granted in the third clock after it was raised, and never earlier.
- R7: Each write request produces exactly one `wr_done` pulse. The requester holds `wr_req` and its data until that pulse.
- R8: During and right after reset, `mem_ce_n`, `mem_oe_n` and all `mem_we_n` are high, and `mem_dq_oe`, `rd_gnt`, `rd_valid` and `wr_done` are low.
- R9: Bit i of `wr_be` enables byte lane i, which is data bits [8i+7:8i]. Only `mem_we_n[i]` for enabled lanes goes low, so bytes in lanes that are not enabled keep their old contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_req | input | 1 | Display fetch request, held until granted |
| rd_addr | input | ADDR_W | Word address of the fetch |
| rd_gnt | output | 1 | Fetch accepted; address is on the RAM this cycle |
| rd_valid | output | 1 | Fetched word available on rd_data |
| rd_data | output | DATA_W | Fetched word |
| wr_req | input | 1 | Captured write request, held until wr_done |
| wr_addr | input | ADDR_W | Word address of the write |
| wr_data | input | DATA_W | Write data |
| wr_be | input | DATA_W/BYTE_W | Byte-lane enables |
| wr_done | output | 1 | Write strobe completing this cycle |
| mem_addr | output | ADDR_W | RAM address |
| mem_ce_n | output | 1 | RAM chip enable, active low |
| mem_oe_n | output | 1 | RAM output enable, active low |
| mem_we_n | output | DATA_W/BYTE_W | Per-lane RAM write enable, active low |
| mem_dout | output | DATA_W | Data driven toward the RAM |
| mem_dq_oe | output | 1 | Enables the data-bus driver toward the RAM |
| mem_din | input | DATA_W | Data returned from the RAM |

## Verification
A scheduler that lands in the wrong state would show up at once at the RAM pins. It could drop the data driver too early, lower a write-enable while the outputs are enabled, or move a grant, and the bench checks these in every cycle. A lane-enable register that is stale or swapped shows up later, when the affected word is read back and one byte differs. If a write is accepted twice, a second done pulse appears one release cycle later. If reads stop taking priority, a write strobe appears inside a continuous read stream.

// File: rtl/vram_arb_pkg.sv
package vram_arb_pkg;
   typedef enum logic [2:0] {
      ST_IDLE      = 3'd0,
      ST_RD_SETUP  = 3'd1,
      ST_RD_STROBE = 3'd2,
      ST_WR_SETUP  = 3'd3,
      ST_WR_STROBE = 3'd4,
      ST_WR_TAIL   = 3'd5
   } arb_state_e;
endpackage

// File: rtl/vram_arb_sched.sv
module vram_arb_sched
   import vram_arb_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       rd_req,
   input  logic       wr_req,
   output arb_state_e state,
   output logic       take_rd,
   output logic       take_wr
);
   arb_state_e nxt;

   // A new access may start only from idle or from the last clock of an access.
   always_comb begin
      nxt     = state;
      take_rd = 1'b0;
      take_wr = 1'b0;
      unique case (state)
         ST_IDLE, ST_RD_STROBE, ST_WR_TAIL: begin
            if (rd_req) begin
               nxt     = ST_RD_SETUP;
               take_rd = 1'b1;
            end else if (wr_req) begin
               nxt     = ST_WR_SETUP;
               take_wr = 1'b1;
            end else begin
               nxt = ST_IDLE;
            end
         end
         ST_RD_SETUP:  nxt = ST_RD_STROBE;
         ST_WR_SETUP:  nxt = ST_WR_STROBE;
         ST_WR_STROBE: nxt = ST_WR_TAIL;
         default:      nxt = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state <= ST_IDLE;
      else        state <= nxt;
   end
endmodule

// File: rtl/vram_arb_lanes.sv
module vram_arb_lanes #(
   parameter int DATA_W = 16,
   parameter int BYTE_W = 8,
   localparam int NLANE = DATA_W / BYTE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              take_wr,
   input  logic              strobe,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [NLANE-1:0]  wr_be,
   output logic [NLANE-1:0]  mem_we_n,
   output logic [DATA_W-1:0] mem_dout
);
   for (genvar g = 0; g < NLANE; g++) begin : g_lane
      logic              en_q;
      logic [BYTE_W-1:0] byte_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            en_q   <= 1'b0;
            byte_q <= '0;
         end else if (take_wr) begin
            en_q   <= wr_be[g];
            byte_q <= wr_data[g*BYTE_W +: BYTE_W];
         end
      end

      assign mem_we_n[g]                    = ~(strobe & en_q);
      assign mem_dout[g*BYTE_W +: BYTE_W]   = byte_q;
   end
endmodule

// File: rtl/vram_arb_capture.sv
module vram_arb_capture #(
   parameter int DATA_W      = 16,
   parameter bit CLEAR_RDATA = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cap,
   input  logic [DATA_W-1:0] mem_din,
   output logic              rd_valid,
   output logic [DATA_W-1:0] rd_data
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rd_valid <= 1'b0;
      else        rd_valid <= cap;
   end

   if (CLEAR_RDATA) begin : g_clr
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)   rd_data <= '0;
         else if (cap) rd_data <= mem_din;
      end
   end else begin : g_noclr
      always_ff @(posedge clk) begin
         if (cap) rd_data <= mem_din;
      end
   end
endmodule

// File: rtl/vram_arbiter.sv
module vram_arbiter
   import vram_arb_pkg::*;
#(
   parameter int ADDR_W      = 15,
   parameter int DATA_W      = 16,
   parameter int BYTE_W      = 8,
   parameter bit CLEAR_RDATA = 1'b1
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       rd_req,
   input  logic [ADDR_W-1:0]          rd_addr,
   output logic                       rd_gnt,
   output logic                       rd_valid,
   output logic [DATA_W-1:0]          rd_data,
   input  logic                       wr_req,
   input  logic [ADDR_W-1:0]          wr_addr,
   input  logic [DATA_W-1:0]          wr_data,
   input  logic [DATA_W/BYTE_W-1:0]   wr_be,
   output logic                       wr_done,
   output logic [ADDR_W-1:0]          mem_addr,
   output logic                       mem_ce_n,
   output logic                       mem_oe_n,
   output logic [DATA_W/BYTE_W-1:0]   mem_we_n,
   output logic [DATA_W-1:0]          mem_dout,
   output logic                       mem_dq_oe,
   input  logic [DATA_W-1:0]          mem_din
);
   localparam int NLANE = DATA_W / BYTE_W;

   if (BYTE_W < 1 || DATA_W % BYTE_W != 0) begin : g_bad_lane
      $error("DATA_W must be a whole number of BYTE_W lanes");
   end
   if (ADDR_W < 1) begin : g_bad_addr
      $error("ADDR_W must be at least 1");
   end
   if (NLANE < 1) begin : g_bad_nlane
      $error("at least one byte lane is required");
   end

   arb_state_e state;
   logic       take_rd, take_wr;

   vram_arb_sched u_sched (
      .clk     (clk),
      .rst_n   (rst_n),
      .rd_req  (rd_req),
      .wr_req  (wr_req),
      .state   (state),
      .take_rd (take_rd),
      .take_wr (take_wr)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       mem_addr <= '0;
      else if (take_rd) mem_addr <= rd_addr;
      else if (take_wr) mem_addr <= wr_addr;
   end

   vram_arb_lanes #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_lanes (
      .clk      (clk),
      .rst_n    (rst_n),
      .take_wr  (take_wr),
      .strobe   (state == ST_WR_STROBE),
      .wr_data  (wr_data),
      .wr_be    (wr_be),
      .mem_we_n (mem_we_n),
      .mem_dout (mem_dout)
   );

   vram_arb_capture #(.DATA_W(DATA_W), .CLEAR_RDATA(CLEAR_RDATA)) u_cap (
      .clk      (clk),
      .rst_n    (rst_n),
      .cap      (state == ST_RD_STROBE),
      .mem_din  (mem_din),
      .rd_valid (rd_valid),
      .rd_data  (rd_data)
   );

   always_comb begin
      rd_gnt    = (state == ST_RD_SETUP);
      wr_done   = (state == ST_WR_STROBE);
      mem_ce_n  = !(state inside {ST_RD_SETUP, ST_RD_STROBE, ST_WR_SETUP, ST_WR_STROBE});
      mem_oe_n  = !(state inside {ST_RD_SETUP, ST_RD_STROBE});
      mem_dq_oe = (state inside {ST_WR_SETUP, ST_WR_STROBE, ST_WR_TAIL});
   end
endmodule

// File: rtl/vram_arb_chk.sv
module vram_arb_chk (
   input logic clk,
   input logic rst_n,
   input logic rd_req,
   input logic rd_gnt,
   input logic rd_valid,
   input logic wr_done,
   input logic mem_ce_n,
   input logic mem_oe_n,
   input logic mem_dq_oe,
   input logic we_lo
);
   a_r1_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
      !(!mem_oe_n && (mem_dq_oe || we_lo)));

   a_r2_valid_after_gnt: assert property (@(posedge clk) disable iff (!rst_n)
      rd_gnt |-> ##2 rd_valid);

   a_r2_valid_needs_gnt: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> $past(rd_gnt, 2));

   a_r3_we_after_setup: assert property (@(posedge clk) disable iff (!rst_n)
      we_lo |-> ($past(mem_dq_oe) && !mem_ce_n));

   a_r3_drive_holds: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(we_lo) |-> (mem_dq_oe && mem_ce_n));

   a_r3_done_in_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      wr_done |-> (mem_dq_oe && !mem_ce_n && $past(mem_dq_oe)));

   a_r7_single_done: assert property (@(posedge clk) disable iff (!rst_n)
      wr_done |=> !wr_done);

   a_r4_read_first: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req && mem_ce_n) |=> rd_gnt);
endmodule

bind vram_arbiter vram_arb_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .rd_req    (rd_req),
   .rd_gnt    (rd_gnt),
   .rd_valid  (rd_valid),
   .wr_done   (wr_done),
   .mem_ce_n  (mem_ce_n),
   .mem_oe_n  (mem_oe_n),
   .mem_dq_oe (mem_dq_oe),
   .we_lo     (~&mem_we_n)
);

// File: tb/tb_vram_arbiter.sv
module tb_vram_arbiter;
   localparam int AW = 15, DW = 16, NB = 2;

   logic clk = 1'b0, rst_n = 1'b0;
   logic rd_req = 1'b0, wr_req = 1'b0;
   logic [AW-1:0] rd_addr = '0, wr_addr = '0;
   logic [DW-1:0] wr_data = '0;
   logic [NB-1:0] wr_be = '0;
   logic rd_gnt, rd_valid, wr_done, mem_ce_n, mem_oe_n, mem_dq_oe;
   logic [DW-1:0] rd_data, mem_dout, mem_din;
   logic [AW-1:0] mem_addr;
   logic [NB-1:0] mem_we_n;

   int n_chk = 0, n_fail = 0, r1_viol = 0;
   bit done_flag = 0;
   logic [DW-1:0] sram [256];
   logic [DW-1:0] ref_mem [256];

   always #5 clk = ~clk;

   vram_arbiter dut (.*);

   assign mem_din = (!mem_ce_n && !mem_oe_n) ? sram[mem_addr[7:0]] : '0;

   always @(posedge clk) begin
      for (int b = 0; b < NB; b++)
         if (!mem_ce_n && !mem_we_n[b] && mem_dq_oe)
            sram[mem_addr[7:0]][b*8 +: 8] <= mem_dout[b*8 +: 8];
   end

   always @(negedge clk)
      if (rst_n && !mem_oe_n && (mem_dq_oe || ~&mem_we_n)) r1_viol++;

   // encoding: {is_write, addr[7:0], data[15:0], be[1:0]}
   localparam logic [26:0] VEC [10] = '{
      {1'b1, 8'h05, 16'hA1B2, 2'b11},
      {1'b1, 8'h06, 16'hC3D4, 2'b11},
      {1'b0, 8'h05, 16'h0000, 2'b00},
      {1'b1, 8'h05, 16'hEEFF, 2'b01},
      {1'b0, 8'h05, 16'h0000, 2'b00},
      {1'b1, 8'h06, 16'h7788, 2'b10},
      {1'b0, 8'h06, 16'h0000, 2'b00},
      {1'b1, 8'h80, 16'h5555, 2'b00},
      {1'b0, 8'h80, 16'h0000, 2'b00},
      {1'b0, 8'h07, 16'h0000, 2'b00}
   };

   task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic ref_write(input logic [7:0] a, input logic [15:0] d, input logic [1:0] be);
      for (int b = 0; b < NB; b++)
         if (be[b]) ref_mem[a][b*8 +: 8] = d[b*8 +: 8];
   endtask

   task automatic do_read(input logic [7:0] a);
      int w = 0;
      rd_addr = {{(AW-8){1'b0}}, a};
      rd_req  = 1'b1;
      @(negedge clk);
      while (!rd_gnt && w < 50) begin w++; @(negedge clk); end
      check(rd_gnt && !mem_ce_n && !mem_oe_n && mem_addr == rd_addr, "R2 grant cycle",
            {mem_ce_n, mem_oe_n, mem_addr}, {2'b00, rd_addr});
      rd_req = 1'b0;
      @(negedge clk);
      check(!rd_valid, "R2 no early valid", rd_valid, 0);
      @(negedge clk);
      check(rd_valid && rd_data == ref_mem[a], "R2 read data", {rd_valid, rd_data}, {1'b1, ref_mem[a]});
   endtask

   task automatic do_write(input logic [7:0] a, input logic [15:0] d, input logic [1:0] be);
      int w = 0;
      wr_addr = {{(AW-8){1'b0}}, a};
      wr_data = d;
      wr_be   = be;
      wr_req  = 1'b1;
      @(negedge clk);
      while (!wr_done && w < 50) begin w++; @(negedge clk); end
      check(wr_done && mem_we_n == ~be && !mem_ce_n, "R9 lane strobes", {wr_done, mem_we_n}, {1'b1, ~be});
      wr_req = 1'b0;
      @(negedge clk);
      check(mem_dq_oe && mem_ce_n && &mem_we_n && !wr_done, "R3 release / R7 one done",
            {mem_dq_oe, mem_ce_n, mem_we_n, wr_done}, {2'b11, 2'b11, 1'b0});
      ref_write(a, d, be);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done_flag) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      int gcnt, dcnt;
      for (int i = 0; i < 256; i++) begin
         sram[i]    = 16'h1000 + 16'(i);
         ref_mem[i] = 16'h1000 + 16'(i);
      end
      repeat (3) @(negedge clk);
      check(mem_ce_n && mem_oe_n && &mem_we_n && !mem_dq_oe && !rd_gnt && !rd_valid && !wr_done,
            "R8 in reset", {mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe}, 5'b11110);
      rst_n = 1'b1;
      @(negedge clk);
      check(mem_ce_n && mem_oe_n && &mem_we_n && !mem_dq_oe && !rd_gnt && !rd_valid && !wr_done,
            "R8 after reset", {mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe}, 5'b11110);

      // vector table
      foreach (VEC[i]) begin
         if (VEC[i][26]) do_write(VEC[i][25:18], VEC[i][17:2], VEC[i][1:0]);
         else            do_read(VEC[i][25:18]);
      end

      // R4: both raised together in idle
      rd_addr = 15'h10; rd_req = 1'b1;
      wr_addr = 15'h11; wr_data = 16'hBEEF; wr_be = 2'b11; wr_req = 1'b1;
      @(negedge clk);
      check(rd_gnt && !wr_done && !mem_dq_oe, "R4 read first", {rd_gnt, wr_done, mem_dq_oe}, 3'b100);
      rd_req = 1'b0;
      @(negedge clk);
      check(!rd_valid && !wr_done, "R4 read strobe", {rd_valid, wr_done}, 2'b00);
      @(negedge clk);
      check(rd_valid && rd_data == ref_mem[8'h10], "R4 read data", rd_data, ref_mem[8'h10]);
      check(mem_dq_oe && !mem_ce_n && &mem_we_n && mem_oe_n, "R3 setup", {mem_dq_oe, mem_ce_n, mem_we_n}, 4'b1011);
      @(negedge clk);
      check(wr_done && mem_we_n == 2'b00, "R3 strobe", {wr_done, mem_we_n}, 3'b100);
      wr_req = 1'b0;
      @(negedge clk);
      check(mem_dq_oe && mem_ce_n && &mem_we_n && !wr_done, "R3 tail", {mem_dq_oe, mem_ce_n, mem_we_n}, 4'b1111);
      ref_write(8'h11, 16'hBEEF, 2'b11);
      @(negedge clk);
      do_read(8'h11);

      // R6: read raised during write setup
      wr_addr = 15'h20; wr_data = 16'h1234; wr_be = 2'b11; wr_req = 1'b1;
      @(negedge clk);
      check(mem_dq_oe && !wr_done, "R6 write setup", mem_dq_oe, 1);
      rd_addr = 15'h20; rd_req = 1'b1;
      @(negedge clk);
      check(!rd_gnt && wr_done, "R6 no grant in strobe", {rd_gnt, wr_done}, 2'b01);
      wr_req = 1'b0;
      @(negedge clk);
      check(!rd_gnt && mem_oe_n, "R6 no grant in release", rd_gnt, 0);
      @(negedge clk);
      check(rd_gnt, "R6 grant on third clock", rd_gnt, 1);
      rd_req = 1'b0;
      ref_write(8'h20, 16'h1234, 2'b11);
      repeat (2) @(negedge clk);
      check(rd_valid && rd_data == 16'h1234, "R6 read sees new data", rd_data, 16'h1234);

      // R5: continuous reads starve the write
      rd_addr = 15'h30; rd_req = 1'b1;
      wr_addr = 15'h31; wr_data = 16'h00AA; wr_be = 2'b01; wr_req = 1'b1;
      gcnt = 0; dcnt = 0;
      for (int k = 0; k < 12; k++) begin
         @(negedge clk);
         if (rd_gnt) gcnt++;
         if (wr_done || ~&mem_we_n) dcnt++;
      end
      check(gcnt == 6, "R5 grant every other clock", gcnt, 6);
      check(dcnt == 0, "R5 write held off", dcnt, 0);
      rd_req = 1'b0;
      @(negedge clk);
      check(!wr_done && mem_dq_oe, "R5 write setup after reads", {wr_done, mem_dq_oe}, 2'b01);
      @(negedge clk);
      check(wr_done && mem_we_n == 2'b10, "R5 write strobe", {wr_done, mem_we_n}, 3'b110);
      wr_req = 1'b0;
      @(negedge clk);
      check(!wr_done, "R7 single done", wr_done, 0);
      ref_write(8'h31, 16'h00AA, 2'b01);
      @(negedge clk);
      do_read(8'h31);
      do_read(8'h30);

      check(r1_viol == 0, "R1 overlap monitor", r1_viol, 0);
      done_flag = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule